// File: doc/BRIEF.md
# Memory Read/Write Turnaround Arbiter

This block chooses the direction of the data bus for a memory controller that holds reads and writes in two separate queues. Each cycle it looks at how full both queues are, at how many bursts have gone out since the bus last changed direction, and at a write-block condition. From these it keeps a mode flag that tells the downstream scheduler which queue the next burst must come from.

Moving from reads to writes needs more than a full write queue. The write queue must be above a high watermark, and the read side must first have issued a minimum number of bursts, unless it has nothing left. Moving back from writes to reads needs a minimum write count and a write queue at or below a low watermark, unless the write queue has drained. An empty read queue hands the bus to any pending write. Both watermarks are set as percentages of the write queue capacity. The burst counters and a one-cycle switch strobe are exported so that the scheduler can track each turnaround.

Top module: `rw_turn_arb`

## Requirements
- R1: After reset the mode is read (`mode_wr`=0), `switch_pulse` is 0 and both counters are 0.
- R2: In read mode each cycle with `rd_issue`=1 adds one to `rd_cnt`. In write mode each cycle with `wr_issue`=1 adds one to `wr_cnt`. A strobe for the direction that is not selected is ignored. Each counter saturates at its all-ones value.
- R3: Both counters are 0 in the cycle after a direction change. A strobe in the switching cycle is not counted.
- R4: In read mode the block switches to write when `wr_occ` is strictly greater than HI, and `rd_cnt` is at least MIN_RD or `rd_occ` is 0. When `wr_occ` equals HI it stays in read mode.
- R5: In read mode with `rd_occ`=0, any nonzero `wr_occ` causes a switch to write, even when `wr_occ` is below HI.
- R6: While `wr_block`=1 the block never switches from read to write.
- R7: In write mode the block returns to read when `wr_cnt` is at least MIN_WR, `wr_occ` is at most LO and `rd_occ` is nonzero. Below MIN_WR it stays in write mode.
- R8: In write mode with `wr_occ`=0 and `rd_occ` nonzero, the block returns to read whatever `wr_cnt` holds. When both queues are empty the mode holds.
- R9: The decision uses the inputs and counters present at a rising edge. The new mode appears after that edge, together with `switch_pulse`=1 for exactly that one cycle. `switch_pulse` is 0 in every cycle without a mode change.
- R10: HI = floor(WQ_DEPTH*HI_PCT/100) and LO = floor(WQ_DEPTH*LO_PCT/100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_occ | input | $clog2(RQ_DEPTH+1) | Occupied read-queue entries |
| wr_occ | input | $clog2(WQ_DEPTH+1) | Occupied write-queue entries |
| rd_issue | input | 1 | A read burst was issued this cycle |
| wr_issue | input | 1 | A write burst was issued this cycle |
| wr_block | input | 1 | Writes cannot issue now (write response path full) |
| mode_wr | output | 1 | 1 = bus serves writes, 0 = bus serves reads |
| switch_pulse | output | 1 | One-cycle strobe on each direction change |
| rd_cnt | output | CNT_W | Reads issued since the last switch |
| wr_cnt | output | CNT_W | Writes issued since the last switch |

## Verification
A counter that fails to clear or fails to count appears on `rd_cnt`/`wr_cnt` in the cycle right after the bad edge. It then moves the next turnaround earlier or later by as many cycles as the count is off. The vector walk is built so that each turnaround falls on the exact cycle where a minimum count is met or a watermark is crossed. A neighbouring case sits one count or one entry short. An off-by-one comparison or a wrong threshold therefore shows up as a mode flip one cycle away from the expected one. A stuck mode register shows up as a missing or extra `switch_pulse` on the first transition.

// File: rtl/rw_turn_pkg.sv
package rw_turn_pkg;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    typedef struct packed {
        dir_e mode;
        logic pulse;
    } turn_st_t;

    function automatic int pct_of(input int depth, input int pct);
        return (depth * pct) / 100;
    endfunction

endpackage

// File: rtl/wq_watermark.sv
module wq_watermark #(
    parameter int WQ_DEPTH = 32,
    parameter int HI_PCT   = 85,
    parameter int LO_PCT   = 50,
    localparam int OCC_W   = $clog2(WQ_DEPTH + 1)
) (
    input  logic [OCC_W-1:0] wr_occ,
    output logic             above_hi,
    output logic             at_or_below_lo,
    output logic             empty
);
    import rw_turn_pkg::*;

    localparam int HI = pct_of(WQ_DEPTH, HI_PCT);
    localparam int LO = pct_of(WQ_DEPTH, LO_PCT);
    localparam logic [OCC_W-1:0] HI_L = OCC_W'(HI);
    localparam logic [OCC_W-1:0] LO_L = OCC_W'(LO);

    always_comb begin
        above_hi       = (wr_occ > HI_L);
        at_or_below_lo = (wr_occ <= LO_L);
        empty          = (wr_occ == '0);
    end

endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != SAT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/turn_fsm.sv
module turn_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_empty,
    input  logic wr_empty,
    input  logic wr_above_hi,
    input  logic wr_at_lo,
    input  logic rd_min_met,
    input  logic wr_min_met,
    input  logic wr_block,
    output logic switch_now,
    output logic mode_wr,
    output logic pulse
);
    import rw_turn_pkg::*;

    turn_st_t st_d, st_q;
    logic     go_wr, go_rd;

    always_comb begin
        go_wr = !wr_block && !wr_empty &&
                (rd_empty || (wr_above_hi && rd_min_met));
        go_rd = !rd_empty && (wr_empty || (wr_min_met && wr_at_lo));

        switch_now = (st_q.mode == DIR_RD) ? go_wr : go_rd;

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (switch_now) begin
            st_d.mode  = (st_q.mode == DIR_RD) ? DIR_WR : DIR_RD;
            st_d.pulse = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: DIR_RD, pulse: 1'b0};
        else        st_q <= st_d;
    end

    assign mode_wr = (st_q.mode == DIR_WR);
    assign pulse   = st_q.pulse;

endmodule

// File: rtl/rw_turn_arb.sv
module rw_turn_arb #(
    parameter int RQ_DEPTH = 32,
    parameter int WQ_DEPTH = 32,
    parameter int HI_PCT   = 85,
    parameter int LO_PCT   = 50,
    parameter int MIN_RD   = 16,
    parameter int MIN_WR   = 16,
    localparam int RQ_OCC_W = $clog2(RQ_DEPTH + 1),
    localparam int WQ_OCC_W = $clog2(WQ_DEPTH + 1),
    localparam int MIN_MAX  = (MIN_RD > MIN_WR) ? MIN_RD : MIN_WR,
    localparam int CNT_W    = $clog2(MIN_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RQ_OCC_W-1:0] rd_occ,
    input  logic [WQ_OCC_W-1:0] wr_occ,
    input  logic                rd_issue,
    input  logic                wr_issue,
    input  logic                wr_block,
    output logic                mode_wr,
    output logic                switch_pulse,
    output logic [CNT_W-1:0]    rd_cnt,
    output logic [CNT_W-1:0]    wr_cnt
);
    localparam logic [CNT_W-1:0] MIN_RD_L = CNT_W'(MIN_RD);
    localparam logic [CNT_W-1:0] MIN_WR_L = CNT_W'(MIN_WR);

    logic wr_above_hi, wr_at_lo, wr_empty, rd_empty;
    logic switch_now;
    logic [1:0]       issue_v;
    logic [CNT_W-1:0] cnt_v [2];

    assign rd_empty = (rd_occ == '0);
    assign issue_v  = {wr_issue, rd_issue};

    wq_watermark #(
        .WQ_DEPTH (WQ_DEPTH),
        .HI_PCT   (HI_PCT),
        .LO_PCT   (LO_PCT)
    ) u_wmark (
        .wr_occ         (wr_occ),
        .above_hi       (wr_above_hi),
        .at_or_below_lo (wr_at_lo),
        .empty          (wr_empty)
    );

    turn_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_empty    (rd_empty),
        .wr_empty    (wr_empty),
        .wr_above_hi (wr_above_hi),
        .wr_at_lo    (wr_at_lo),
        .rd_min_met  (cnt_v[0] >= MIN_RD_L),
        .wr_min_met  (cnt_v[1] >= MIN_WR_L),
        .wr_block    (wr_block),
        .switch_now  (switch_now),
        .mode_wr     (mode_wr),
        .pulse       (switch_pulse)
    );

    // index 0 counts reads, index 1 counts writes
    for (genvar g = 0; g < 2; g++) begin : g_cnt
        burst_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (switch_now),
            .inc   (issue_v[g] && (mode_wr == 1'(g))),
            .cnt   (cnt_v[g])
        );
    end

    assign rd_cnt = cnt_v[0];
    assign wr_cnt = cnt_v[1];

    a_r9_pulse_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr != $past(mode_wr)) |-> switch_pulse);

    a_r3_counts_clear: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse |-> (rd_cnt == '0 && wr_cnt == '0));

    a_r6_no_blocked_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_pulse && mode_wr) |-> !$past(wr_block));

    a_r4_min_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_pulse && mode_wr) |-> ($past(rd_cnt) >= MIN_RD_L || $past(rd_occ) == '0));

    a_r8_write_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_pulse && !mode_wr) |->
            ($past(rd_occ) != '0 && ($past(wr_occ) == '0 || $past(wr_cnt) >= MIN_WR_L)));

    a_r2_idle_counter: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr ? (rd_cnt == '0) : (wr_cnt == '0));

endmodule

// File: tb/rw_turn_arb_tb.sv
module rw_turn_arb_tb;

    // bench parameters: HI = 16*75/100 = 12, LO = 16*25/100 = 4 (R10)
    localparam int RQ_DEPTH = 16;
    localparam int WQ_DEPTH = 16;
    localparam int HI_PCT   = 75;
    localparam int LO_PCT   = 25;
    localparam int MIN_RD   = 4;
    localparam int MIN_WR   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] rd_occ = '0;
    logic [4:0] wr_occ = '0;
    logic       rd_issue = 1'b0;
    logic       wr_issue = 1'b0;
    logic       wr_block = 1'b0;
    logic       mode_wr, switch_pulse;
    logic [2:0] rd_cnt, wr_cnt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rw_turn_arb #(
        .RQ_DEPTH (RQ_DEPTH), .WQ_DEPTH (WQ_DEPTH),
        .HI_PCT   (HI_PCT),   .LO_PCT   (LO_PCT),
        .MIN_RD   (MIN_RD),   .MIN_WR   (MIN_WR)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .rd_occ (rd_occ), .wr_occ (wr_occ),
        .rd_issue (rd_issue), .wr_issue (wr_issue), .wr_block (wr_block),
        .mode_wr (mode_wr), .switch_pulse (switch_pulse),
        .rd_cnt (rd_cnt), .wr_cnt (wr_cnt)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic [4:0] ro;
        logic [4:0] wo;
        logic       ri;
        logic       wi;
        logic       bk;
        logic       em;
        logic       ep;
        logic [2:0] erc;
        logic [2:0] ewc;
    } vec_t;

    localparam int NV = 28;
    // fields: req, rd_occ, wr_occ, rd_issue, wr_issue, wr_block | mode, pulse, rd_cnt, wr_cnt
    localparam vec_t VEC [NV] = '{
        '{4'd2,  5'd5,  5'd3,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0}, // R2 count read
        '{4'd4,  5'd5,  5'd13, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0}, // R4 min not met
        '{4'd4,  5'd5,  5'd13, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 3'd0},
        '{4'd4,  5'd5,  5'd13, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 3'd0},
        '{4'd3,  5'd5,  5'd13, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 3'd0}, // R4 switch, R3 strobe dropped
        '{4'd9,  5'd5,  5'd13, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd1}, // R9 pulse one cycle
        '{4'd7,  5'd5,  5'd3,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd2}, // R7 below MIN_WR
        '{4'd2,  5'd5,  5'd3,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd3}, // R2 read strobe ignored
        '{4'd7,  5'd5,  5'd3,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0}, // R7 return to read
        '{4'd4,  5'd5,  5'd13, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0}, // R4 count 0
        '{4'd6,  5'd0,  5'd2,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0}, // R6 blocked
        '{4'd5,  5'd0,  5'd2,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 3'd0}, // R5 read empty
        '{4'd8,  5'd0,  5'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0}, // R8 both empty hold
        '{4'd8,  5'd3,  5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0}, // R8 write drained
        '{4'd6,  5'd0,  5'd13, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0}, // R6 blocked above HI
        '{4'd5,  5'd0,  5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0}, // R5 nothing pending
        '{4'd2,  5'd3,  5'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0},
        '{4'd2,  5'd3,  5'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0},
        '{4'd2,  5'd3,  5'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 3'd0},
        '{4'd2,  5'd3,  5'd12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 3'd0},
        '{4'd10, 5'd3,  5'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 3'd0}, // R10 equal HI holds
        '{4'd6,  5'd3,  5'd13, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 3'd0}, // R6 blocked, min met
        '{4'd4,  5'd3,  5'd13, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 3'd0}, // R4 switch
        '{4'd2,  5'd3,  5'd5,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd1},
        '{4'd2,  5'd3,  5'd5,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd2},
        '{4'd2,  5'd3,  5'd5,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd3},
        '{4'd10, 5'd3,  5'd5,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd3}, // R10 above LO holds
        '{4'd7,  5'd3,  5'd4,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0}  // R7 at LO returns
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int em, input int ep, input int erc, input int ewc);
        chk(req, "mode_wr", int'(mode_wr), em);
        chk(req, "switch_pulse", int'(switch_pulse), ep);
        chk(req, "rd_cnt", int'(rd_cnt), erc);
        chk(req, "wr_cnt", int'(wr_cnt), ewc);
    endtask

    task automatic step(input logic [4:0] ro, input logic [4:0] wo,
                        input logic ri, input logic wi, input logic bk);
        @(negedge clk);
        rd_occ = ro; wr_occ = wo; rd_issue = ri; wr_issue = wi; wr_block = bk;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        chk_all("R1", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].ro, VEC[i].wo, VEC[i].ri, VEC[i].wi, VEC[i].bk);
            chk_all($sformatf("R%0d step %0d", VEC[i].rq, i), int'(VEC[i].em),
                    int'(VEC[i].ep), int'(VEC[i].erc), int'(VEC[i].ewc));
        end

        // R2 saturation: read mode, write queue empty, ten read strobes
        for (int k = 0; k < 10; k++) step(5'd3, 5'd0, 1'b1, 1'b0, 1'b0);
        chk_all("R2 saturate", 0, 0, 7, 0);
        // R2 write strobe ignored in read mode
        step(5'd3, 5'd0, 1'b0, 1'b1, 1'b0);
        chk("R2", "wr_cnt idle", int'(wr_cnt), 0);

        // R5 then R1 reset from write mode
        step(5'd0, 5'd1, 1'b0, 1'b0, 1'b0);
        chk("R5", "mode_wr", int'(mode_wr), 1);
        step(5'd0, 5'd1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk_all("R1 mid-run reset", 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule